// File: doc/BRIEF.md
# RC Charge-Time Tristate Sensor

This block decides whether an external line attached to a bidirectional pad is being held high, held low, or left floating. The pad has a resistor-capacitor network on it and a weak pull-up that the block can switch. A measurement has three steps. The block drives the pad low for a short while to empty the capacitor. It then releases the pad with the pull-up on and counts clock cycles until the pad reads high. The length of that rise sorts the line into one of three classes. A line held high recovers quickly. A floating line recovers slowly, through the weak pull-up alone. A line held low never recovers before the cycle limit is reached.

The discharge length, the fast/slow threshold and the cycle limit are run-time inputs. The block samples them when each measurement begins. A single start pulse runs one measurement. With the repeat input held high, each report is followed at once by a new discharge. The pad input is asynchronous and passes through a two-flop synchronizer before it is counted.

Top module: `rc_tristate_sensor`

## Requirements
- R1: After reset the pad is released (pad_oe_o=0), the pull-up is on, valid_o=0, level_o=2'b00 and count_o=0.
- R2: A start_i sampled high while idle begins a discharge: pad_oe_o=1 for max(pulse_len_i, 2) cycles, beginning in the cycle after that edge.
- R3: pad_out_o is always 0, and pullup_en_o is 0 in exactly the cycles in which pad_oe_o is 1.
- R4: After the discharge the pad is released with the pull-up on, and count_o reports the number of cycles spent measuring before a synchronized high sample is seen. If the pad goes high just before the N-th clock edge after release (N>=1), the count is N+1.
- R5: A count at or below the threshold reports level_o=2'b01 (line driven high). A larger count reports level_o=2'b10 (line floating).
- R6: If the count reaches timeout_i with no high sample, the block reports level_o=2'b00 (line driven low) and count_o=timeout_i. A high sample in that same cycle takes priority.
- R7: valid_o is high for exactly one cycle, the cycle after measurement ends. level_o and count_o change only when valid_o rises and hold until the next report.
- R8: start_i has no effect while a measurement is in progress or being reported.
- R9: With auto_i high at the report cycle, the next discharge starts in the following cycle without a start pulse. With auto_i low, the block returns to idle.
- R10: pulse_len_i, thresh_i and timeout_i are sampled at the edge that begins a measurement. Changes during the measurement do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one measurement when idle |
| auto_i | input | 1 | Repeat measurements back to back |
| pulse_len_i | input | CW | Discharge length in cycles (minimum 2 applied) |
| thresh_i | input | CW | Largest count that still means driven high |
| timeout_i | input | CW | Count at which the line is declared driven low |
| pad_in_i | input | 1 | Asynchronous pad input level |
| pad_oe_o | output | 1 | Pad output enable |
| pad_out_o | output | 1 | Pad output value (always low) |
| pullup_en_o | output | 1 | Weak pull-up enable |
| level_o | output | 2 | 00 driven low, 01 driven high, 10 floating |
| count_o | output | CW | Measured cycle count of the last report |
| valid_o | output | 1 | One-cycle report strobe |

## Verification
The properties assume that start_i, auto_i and the three configuration inputs are synchronous to clk. They also assume pad_in_i falls to low while the pad is being driven low, so that the synchronizer holds only low samples when the measurement window opens. The bench meets both assumptions. It changes every control input at the falling clock edge, and its pad model forces pad_in_i low in every cycle where pad_oe_o is high. It then raises pad_in_i a chosen number of cycles after release, or never for a line driven low. Rise times are chosen to fall on each side of the threshold and of the timeout, and exactly on them.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

    // Depth of the pad-input synchronizer and shortest discharge allowed.
    localparam int SYNC_DEPTH = 2;
    localparam int MIN_PULSE  = 2;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_DISCHARGE = 2'd1,
        ST_MEASURE   = 2'd2,
        ST_REPORT    = 2'd3
    } tsense_state_e;

    typedef enum logic [1:0] {
        LVL_LOW   = 2'b00,
        LVL_HIGH  = 2'b01,
        LVL_FLOAT = 2'b10
    } tsense_level_e;

    // Events that close a measurement window.
    typedef struct packed {
        logic hit;     // synchronized pad seen high
        logic expire;  // count reached the limit without a high sample
    } meas_evt_t;

    // Grade a closed window: a high sample with a short count means driven
    // high, a high sample with a long count means floating, otherwise low.
    function automatic tsense_level_e grade(input logic hit, input logic fast);
        if (!hit)
            return LVL_LOW;
        else if (fast)
            return LVL_HIGH;
        else
            return LVL_FLOAT;
    endfunction

endpackage

// File: rtl/tsense_sync.sv
module tsense_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[0] <= 1'b0;
                else     chain_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= 1'b0;
                else     chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tsense_seq.sv
module tsense_seq
    import tsense_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          auto_i,
    input  logic          sense_i,
    input  logic [CW-1:0] pulse_len_i,
    input  logic [CW-1:0] timeout_i,
    output tsense_state_e state_o,
    output logic          launch_o,
    output meas_evt_t     evt_o,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] PULSE_FLOOR = CW'(MIN_PULSE);
    localparam logic [CW-1:0] ONE         = CW'(1);

    tsense_state_e st_q, st_d;
    logic [CW-1:0] pcnt_q;
    logic [CW-1:0] mcnt_q;
    logic [CW-1:0] pulse_eff;
    logic          pulse_last;
    logic          window_end;

    always_comb begin
        launch_o   = ((st_q == ST_IDLE) && start_i) || ((st_q == ST_REPORT) && auto_i);
        pulse_eff  = (pulse_len_i < PULSE_FLOOR) ? PULSE_FLOOR : pulse_len_i;
        pulse_last = (pcnt_q == ONE);
        evt_o.hit    = (st_q == ST_MEASURE) && sense_i;
        evt_o.expire = (st_q == ST_MEASURE) && !sense_i && (mcnt_q == timeout_i);
        window_end   = evt_o.hit || evt_o.expire;
    end

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:      if (launch_o)   st_d = ST_DISCHARGE;
            ST_DISCHARGE: if (pulse_last) st_d = ST_MEASURE;
            ST_MEASURE:   if (window_end) st_d = ST_REPORT;
            ST_REPORT:    st_d = launch_o ? ST_DISCHARGE : ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pcnt_q <= '0;
            mcnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (launch_o)
                pcnt_q <= pulse_eff;
            else if ((st_q == ST_DISCHARGE) && !pulse_last)
                pcnt_q <= pcnt_q - ONE;

            if (st_q == ST_DISCHARGE)
                mcnt_q <= '0;
            else if ((st_q == ST_MEASURE) && !window_end)
                mcnt_q <= mcnt_q + ONE;
        end
    end

    assign state_o = st_q;
    assign cnt_o   = mcnt_q;

endmodule

// File: rtl/tsense_classify.sv
module tsense_classify
    import tsense_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  meas_evt_t     evt_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] thr_i,
    output logic [1:0]    level_o,
    output logic [CW-1:0] count_o
);

    tsense_level_e level_q;
    logic [CW-1:0] count_q;
    logic          fast;

    assign fast = (cnt_i <= thr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= LVL_LOW;
            count_q <= '0;
        end else if (evt_i.hit || evt_i.expire) begin
            level_q <= grade(evt_i.hit, fast);
            count_q <= cnt_i;
        end
    end

    assign level_o = level_q;
    assign count_o = count_q;

endmodule

// File: rtl/rc_tristate_sensor.sv
module rc_tristate_sensor
    import tsense_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          auto_i,
    input  logic [CW-1:0] pulse_len_i,
    input  logic [CW-1:0] thresh_i,
    input  logic [CW-1:0] timeout_i,
    input  logic          pad_in_i,
    output logic          pad_oe_o,
    output logic          pad_out_o,
    output logic          pullup_en_o,
    output logic [1:0]    level_o,
    output logic [CW-1:0] count_o,
    output logic          valid_o
);

    tsense_state_e state;
    logic          launch;
    logic          sense;
    meas_evt_t     evt;
    logic [CW-1:0] mcnt;
    logic [CW-1:0] thr_q;
    logic [CW-1:0] to_q;

    // Limits are frozen at the edge that begins each measurement.
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
            to_q  <= '0;
        end else if (launch) begin
            thr_q <= thresh_i;
            to_q  <= timeout_i;
        end
    end

    tsense_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pad_in_i),
        .q_o (sense)
    );

    tsense_seq #(.CW(CW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .auto_i      (auto_i),
        .sense_i     (sense),
        .pulse_len_i (pulse_len_i),
        .timeout_i   (to_q),
        .state_o     (state),
        .launch_o    (launch),
        .evt_o       (evt),
        .cnt_o       (mcnt)
    );

    tsense_classify #(.CW(CW)) u_cls (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt),
        .cnt_i   (mcnt),
        .thr_i   (thr_q),
        .level_o (level_o),
        .count_o (count_o)
    );

    // Pad control: drive low only while discharging; pull-up off meanwhile.
    assign pad_oe_o    = (state == ST_DISCHARGE);
    assign pad_out_o   = 1'b0;
    assign pullup_en_o = (state != ST_DISCHARGE);
    assign valid_o     = (state == ST_REPORT);

endmodule

// File: rtl/tsense_chk.sv
module tsense_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          pad_oe,
    input logic          pad_out,
    input logic          pullup_en,
    input logic          valid,
    input logic [1:0]    level,
    input logic [CW-1:0] count,
    input logic [CW-1:0] thr_q,
    input logic [CW-1:0] to_q
);

    // R3
    drive_excl_chk: assert property (@(posedge clk) disable iff (rst)
        pad_oe |-> (!pullup_en && !pad_out));

    // R2
    pulse_floor_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pad_oe) |=> pad_oe);

    // R4
    release_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(!pad_oe));

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |-> ($stable(level) && $stable(count)));

    // R5
    fast_grade_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && level == 2'b01) |-> (count <= thr_q));

    // R5
    slow_grade_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && level == 2'b10) |-> (count > thr_q));

    // R5
    code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> (level != 2'b11));

    // R6
    expire_count_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && level == 2'b00) |-> (count == to_q));

endmodule

bind rc_tristate_sensor tsense_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pad_oe    (pad_oe_o),
    .pad_out   (pad_out_o),
    .pullup_en (pullup_en_o),
    .valid     (valid_o),
    .level     (level_o),
    .count     (count_o),
    .thr_q     (thr_q),
    .to_q      (to_q)
);

// File: tb/sim_rc_tristate_sensor.sv
module sim_rc_tristate_sensor;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          auto_m = 1'b0;
    logic [CW-1:0] plen = 16'd4;
    logic [CW-1:0] thr = 16'd10;
    logic [CW-1:0] tmo = 16'd50;
    logic          pad_in = 1'b0;
    logic          pad_oe, pad_out, pullup_en, valid;
    logic [1:0]    level;
    logic [CW-1:0] count;

    rc_tristate_sensor #(.CW(CW)) u0 (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .auto_i      (auto_m),
        .pulse_len_i (plen),
        .thresh_i    (thr),
        .timeout_i   (tmo),
        .pad_in_i    (pad_in),
        .pad_oe_o    (pad_oe),
        .pad_out_o   (pad_out),
        .pullup_en_o (pullup_en),
        .level_o     (level),
        .count_o     (count),
        .valid_o     (valid)
    );

    always #4 clk = ~clk;

    // External line model: 0 = held low, 1 = held high, 2 = floating.
    // The node reads high ext_rise cycles after the pad stops driving.
    int ext_mode = 1;
    int ext_rise = 3;
    int age = 0;
    always @(negedge clk) begin
        if (pad_oe) age = 0;
        else        age = age + 1;
        pad_in = (ext_mode != 0) && (age >= ext_rise);
    end

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One measurement, checked every cycle at the falling edge.
    task automatic run_meas(input int mode, input int rise, input int p, input int t,
                            input int th, input bit disturb, input bit pre, input string tag);
        int pe, cnt_e, lvl_e;
        ext_mode = mode;
        ext_rise = rise;
        if (!pre) begin
            @(negedge clk);
            plen = CW'(p); thr = CW'(th); tmo = CW'(t); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end else begin
            @(negedge clk);
            auto_m = 1'b0;
            chk(pad_oe == 1'b1, "R9 back-to-back discharge", int'(pad_oe), 1);
        end
        if (disturb) begin
            start = 1'b1;
            plen = 16'd1; thr = 16'd0; tmo = 16'd0;
        end
        pe = (p < 2) ? 2 : p;
        if (mode == 0 || rise + 1 > t) begin
            cnt_e = t; lvl_e = 0;
        end else begin
            cnt_e = rise + 1; lvl_e = (cnt_e <= th) ? 1 : 2;
        end
        for (int i = 0; i < pe; i++) begin
            if (i > 0) @(negedge clk);
            chk(pad_oe == 1'b1,    "R2 discharge oe", int'(pad_oe), 1);
            chk(pullup_en == 1'b0, "R3 pull-up off", int'(pullup_en), 0);
            chk(pad_out == 1'b0,   "R3 drive value", int'(pad_out), 0);
            chk(valid == 1'b0,     "R7 no strobe", int'(valid), 0);
        end
        for (int i = 0; i <= cnt_e; i++) begin
            @(negedge clk);
            chk(pad_oe == 1'b0,    "R4 released", int'(pad_oe), 0);
            chk(pullup_en == 1'b1, "R4 pull-up on", int'(pullup_en), 1);
            chk(valid == 1'b0,     "R4 measuring", int'(valid), 0);
        end
        @(negedge clk);
        chk(valid == 1'b1,       {tag, " strobe"}, int'(valid), 1);
        chk(int'(level) == lvl_e, {tag, " level"}, int'(level), lvl_e);
        chk(int'(count) == cnt_e, {tag, " count"}, int'(count), cnt_e);
        if (disturb) start = 1'b0;
    endtask

    task automatic hold_check(input int lvl_e, input int cnt_e);
        repeat (3) begin
            @(negedge clk);
            chk(valid == 1'b0,        "R7 single strobe", int'(valid), 0);
            chk(pad_oe == 1'b0,       "R9 idle after report", int'(pad_oe), 0);
            chk(int'(level) == lvl_e, "R7 level held", int'(level), lvl_e);
            chk(int'(count) == cnt_e, "R7 count held", int'(count), cnt_e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(pad_oe == 1'b0,    "R1 oe", int'(pad_oe), 0);
        chk(pullup_en == 1'b1, "R1 pull-up", int'(pullup_en), 1);
        chk(valid == 1'b0,     "R1 valid", int'(valid), 0);
        chk(level == 2'b00,    "R1 level", int'(level), 0);
        chk(count == '0,       "R1 count", int'(count), 0);

        // R5 driven high, short rise
        run_meas(1, 3, 4, 50, 10, 1'b0, 1'b0, "R5 high");
        hold_check(1, 4);
        // R5 floating, long rise
        run_meas(2, 20, 4, 50, 10, 1'b0, 1'b0, "R5 float");
        // R6 driven low, never rises
        run_meas(0, 1, 3, 30, 10, 1'b0, 1'b0, "R6 low");
        hold_check(0, 30);
        // R5 threshold boundary: count equal to and one above the threshold
        run_meas(1, 9, 4, 50, 10, 1'b0, 1'b0, "R5 at threshold");
        run_meas(2, 10, 4, 50, 10, 1'b0, 1'b0, "R5 above threshold");
        // R6 timeout boundary: hit on the limit wins, one later expires
        run_meas(2, 29, 5, 30, 10, 1'b0, 1'b0, "R6 hit at limit");
        run_meas(2, 30, 5, 30, 10, 1'b0, 1'b0, "R6 expire at limit");
        // R2 pulse floor with lengths 0 and 1
        run_meas(1, 1, 0, 40, 10, 1'b0, 1'b0, "R2 zero length");
        run_meas(1, 1, 1, 40, 10, 1'b0, 1'b0, "R2 unit length");
        // R6 zero timeout
        run_meas(0, 1, 2, 0, 10, 1'b0, 1'b0, "R6 zero limit");
        // R8 and R10: start held and limits changed during the run
        run_meas(1, 5, 6, 40, 8, 1'b1, 1'b0, "R8 R10 disturbed");
        hold_check(1, 6);
        // R9 repeat mode: two measurements back to back
        auto_m = 1'b1;
        run_meas(1, 2, 3, 40, 10, 1'b0, 1'b0, "R9 first");
        run_meas(2, 15, 3, 40, 10, 1'b0, 1'b1, "R9 second");
        hold_check(2, 16);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule